// File: doc/BRIEF.md
# Slave Parallel Configuration Port

This block receives a configuration bitstream from an external master over a synchronous parallel bus that is either 8 or 16 bits wide. The master writes a beat by holding both its active-low select and write strobes low across a rising clock edge. It may leave any number of idle cycles between beats. The block packs the accepted beats into 32-bit words with the least significant part first. It checks that the first word is the synchronisation pattern, then forwards every later word to the downstream configuration logic as a one-cycle valid pulse with data.

After reset is released, the port stays closed for a fixed number of clock cycles, and beats offered during that window are dropped. A wrong synchronisation word raises a one-cycle error pulse and locks the port until the next reset. When the downstream logic signals completion after at least one word has been forwarded, the ready output rises and stays high until reset. From then on, further beats are discarded.

Top module: `cfg_par_port`

## Requirements
- R1: While reset is low and in the cycle after it, `word_vld`, `err` and `ready` are all 0.
- R2: A beat is taken at a rising edge only when `sel_n` and `wr_n` are both 0. A cycle with `sel_n`=0 and `wr_n`=1 adds nothing to the word being built.
- R3: Any number of idle cycles between beats (both strobes high) leaves the word being built intact.
- R4: The first 50 rising edges after reset is released accept no beat. The 51st edge is the first that can accept one.
- R5: With `wide_i`=0, each beat carries `bus_d[7:0]`, and four beats form a word. The first beat lands in bits 7:0 and the fourth in bits 31:24.
- R6: With `wide_i`=1, each beat carries `bus_d[15:0]`, and two beats form a word. The first beat lands in bits 15:0.
- R7: The first assembled word after reset must equal 32'h12345678, and it is not forwarded. Each later word appears on `word_dat` with `word_vld` high for exactly one cycle, two edges after the edge that took its last beat.
- R8: If the first word differs from 32'h12345678, `err` is high for exactly one cycle, two edges after the last beat. No word is forwarded after that until reset.
- R9: `ready` rises at the edge where `done_i` is seen high, provided a word was forwarded at an earlier edge, and it stays high until reset. A `done_i` seen before any word has been forwarded has no effect.
- R10: Once `ready` is high, beats are discarded and `word_vld` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; beats are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_i | input | 1 | Static bus width select: 0 = 8-bit, 1 = 16-bit |
| sel_n | input | 1 | Active-low select strobe from the master |
| wr_n | input | 1 | Active-low write strobe from the master |
| bus_d | input | BUS_W | Beat data; only the low half is used in 8-bit mode |
| done_i | input | 1 | Completion indication from downstream logic |
| word_vld | output | 1 | One-cycle pulse marking a forwarded word |
| word_dat | output | WORD_W | Forwarded word, valid while `word_vld` is high |
| ready | output | 1 | Sticky configuration-complete flag |
| err | output | 1 | One-cycle pulse on a synchronisation mismatch |

## Verification
The bench drives beats from edge 1 after reset release. A port that opened one edge early would take a stray byte into the sync word and raise `err`, and one that opened late would misalign every later word. Beats with select low and write high are interleaved with idle gaps. A port that took them, or that lost its byte position across a gap, would produce wrong words. A wrong first word is sent to confirm a single error pulse with no forwarded data. `done_i` is asserted before any word and again after forwarding, which catches a ready flag that rises too early, falls back, or lets later beats through.

// File: rtl/cfg_par_pkg.sv
package cfg_par_pkg;

    // Phase of the word-level controller
    typedef enum logic [1:0] {
        PH_SYNC = 2'd0,   // waiting for the synchronisation word
        PH_LOAD = 2'd1,   // forwarding words downstream
        PH_LOCK = 2'd2,   // bad sync seen, port dead until reset
        PH_DONE = 2'd3    // downstream reported completion
    } phase_e;

endpackage

// File: rtl/cfgp_gate.sv
module cfgp_gate #(
    parameter int BLACKOUT = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sel_n,
    input  logic wr_n,
    output logic beat_o
);
    localparam int CW = $clog2(BLACKOUT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          open;
    } gate_s;

    gate_s gate_d, gate_q;

    always_comb begin
        gate_d = gate_q;
        if (!gate_q.open) begin
            gate_d.cnt = gate_q.cnt + 1'b1;
            if (gate_q.cnt == CW'(BLACKOUT - 1)) begin
                gate_d.open = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    // R2: both strobes low qualify a beat; R4: only once the window has elapsed
    assign beat_o = gate_q.open && en_i && !sel_n && !wr_n;

    // R4: the window never reopens once it has elapsed
    a_r4_open_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q.open |=> gate_q.open);

endmodule

// File: rtl/cfgp_pack.sv
module cfgp_pack #(
    parameter int WORD_W = 32,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_i,
    input  logic              wide_i,
    input  logic [BUS_W-1:0]  bus_i,
    output logic              full_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int NARROW_W = BUS_W / 2;
    localparam int NB_WIDE  = WORD_W / BUS_W;
    localparam int NB_NAR   = WORD_W / NARROW_W;
    localparam int PW       = $clog2(NB_NAR);

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [PW-1:0]     pos;
        logic              full;
    } pack_s;

    pack_s pk_d, pk_q;
    logic  last;

    always_comb begin
        pk_d      = pk_q;
        pk_d.full = 1'b0;
        last      = 1'b0;
        if (beat_i) begin
            if (wide_i) begin
                // R6: newest halfword enters at the top, so the first lands lowest
                pk_d.acc = {bus_i, pk_q.acc[WORD_W-1:BUS_W]};
                last     = (pk_q.pos == PW'(NB_WIDE - 1));
            end else begin
                // R5: same shifting with byte beats
                pk_d.acc = {bus_i[NARROW_W-1:0], pk_q.acc[WORD_W-1:NARROW_W]};
                last     = (pk_q.pos == PW'(NB_NAR - 1));
            end
            if (last) begin
                pk_d.pos  = '0;
                pk_d.full = 1'b1;
            end else begin
                pk_d.pos  = pk_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign full_o = pk_q.full;
    assign word_o = pk_q.acc;

    // R6: a word takes at least two beats, so completions never touch
    a_r6_full_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        pk_q.full |=> !pk_q.full);

endmodule

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl
    import cfg_par_pkg::*;
#(
    parameter int              WORD_W    = 32,
    parameter logic [WORD_W-1:0] SYNC_WORD = 32'h1234_5678
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              done_i,
    output logic              accept_o,
    output logic              vld_o,
    output logic [WORD_W-1:0] dat_o,
    output logic              ready_o,
    output logic              err_o
);
    typedef struct packed {
        phase_e            ph;
        logic              any;
        logic              vld;
        logic              err;
        logic [WORD_W-1:0] dat;
    } ctrl_s;

    ctrl_s ct_d, ct_q;

    always_comb begin
        ct_d     = ct_q;
        ct_d.vld = 1'b0;
        ct_d.err = 1'b0;
        unique case (ct_q.ph)
            PH_SYNC: begin
                if (full_i) begin
                    if (word_i == SYNC_WORD) begin
                        ct_d.ph  = PH_LOAD;
                    end else begin
                        ct_d.ph  = PH_LOCK;
                        ct_d.err = 1'b1;
                    end
                end
            end
            PH_LOAD: begin
                if (full_i) begin
                    ct_d.vld = 1'b1;
                    ct_d.dat = word_i;
                    ct_d.any = 1'b1;
                end
                if (done_i && ct_q.any) begin
                    ct_d.ph = PH_DONE;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ct_q <= '0;
        else        ct_q <= ct_d;
    end

    assign accept_o = (ct_q.ph == PH_SYNC) || (ct_q.ph == PH_LOAD);
    assign vld_o    = ct_q.vld;
    assign dat_o    = ct_q.dat;
    assign err_o    = ct_q.err;
    assign ready_o  = (ct_q.ph == PH_DONE);

    // R9: ready only after a word went out at an earlier edge
    a_r9_ready_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(ct_q.any));

    // R8: a locked port stays locked and silent
    a_r8_lock_final: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.ph == PH_LOCK) |=> ((ct_q.ph == PH_LOCK) && !vld_o));

endmodule

// File: rtl/cfg_par_port.sv
module cfg_par_port #(
    parameter int                WORD_W    = 32,
    parameter int                BUS_W     = 16,
    parameter int                BLACKOUT  = 50,
    parameter logic [WORD_W-1:0] SYNC_WORD = 32'h1234_5678
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_i,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [BUS_W-1:0]  bus_d,
    input  logic              done_i,
    output logic              word_vld,
    output logic [WORD_W-1:0] word_dat,
    output logic              ready,
    output logic              err
);
    localparam int AW = $clog2(BLACKOUT + 2);

    logic              accept;
    logic              beat;
    logic              full;
    logic [WORD_W-1:0] word;

    cfgp_gate #(.BLACKOUT(BLACKOUT)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (accept),
        .sel_n  (sel_n),
        .wr_n   (wr_n),
        .beat_o (beat)
    );

    cfgp_pack #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat_i (beat),
        .wide_i (wide_i),
        .bus_i  (bus_d),
        .full_o (full),
        .word_o (word)
    );

    cfgp_ctrl #(.WORD_W(WORD_W), .SYNC_WORD(SYNC_WORD)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .full_i   (full),
        .word_i   (word),
        .done_i   (done_i),
        .accept_o (accept),
        .vld_o    (word_vld),
        .dat_o    (word_dat),
        .ready_o  (ready),
        .err_o    (err)
    );

    // Edge counter since reset release, used only by the checks below
    logic [AW-1:0] age_d, age_q;
    always_comb begin
        age_d = age_q;
        if (age_q != AW'(BLACKOUT + 1)) age_d = age_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    // R4: nothing can come out while the port is still closed
    a_r4_blackout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q <= AW'(BLACKOUT)) |-> (!word_vld && !err));

    // R8: error is a single-cycle pulse
    a_r8_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R7: forwarded words are single-cycle pulses
    a_r7_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    // R9: ready holds until reset
    a_r9_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R10: no words after completion
    a_r10_silent_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ready) |-> !word_vld);

endmodule

// File: tb/cfg_par_port_tb.sv
`timescale 1ns/1ps
module cfg_par_port_tb;

    localparam logic [31:0] SYNC = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_i = 1'b0;
    logic        sel_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] bus_d = '0;
    logic        done_i = 1'b0;
    logic        word_vld;
    logic [31:0] word_dat;
    logic        ready;
    logic        err;

    always #10 clk = ~clk;   // 50 MHz

    cfg_par_port u_dut (
        .clk(clk), .rst_n(rst_n), .wide_i(wide_i), .sel_n(sel_n), .wr_n(wr_n),
        .bus_d(bus_d), .done_i(done_i), .word_vld(word_vld), .word_dat(word_dat),
        .ready(ready), .err(err)
    );

    int n_vec = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_edges;      // edges since release
    int          m_ph;         // 0 sync, 1 load, 2 locked, 3 done
    bit          m_any;
    byte         m_bytes[$];
    bit          p_full;
    bit [31:0]   p_word;
    bit          e_vld, e_err;
    bit [31:0]   e_dat;
    int          t_ph;
    bit          t_any, t_full;
    bit [31:0]   t_word;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_edges = 0; m_ph = 0; m_any = 0; m_bytes.delete();
            p_full = 0; p_word = '0; e_vld = 0; e_err = 0; e_dat = '0;
        end else begin
            t_ph = m_ph; t_any = m_any; t_full = p_full; t_word = p_word;
            e_vld = 0; e_err = 0;
            if (t_ph == 0 && t_full) begin
                if (t_word == SYNC) m_ph = 1;
                else begin m_ph = 2; e_err = 1; end
            end else if (t_ph == 1) begin
                if (t_full) begin e_vld = 1; e_dat = t_word; m_any = 1; end
                if (done_i && t_any) m_ph = 3;
            end
            p_full = 0;
            if (m_edges >= 50 && t_ph <= 1 && !sel_n && !wr_n) begin
                m_bytes.push_back(bus_d[7:0]);
                if (wide_i) m_bytes.push_back(bus_d[15:8]);
                if (m_bytes.size() >= 4) begin
                    p_word = {m_bytes[3], m_bytes[2], m_bytes[1], m_bytes[0]};
                    p_full = 1;
                    m_bytes.delete();
                end
            end
            if (m_edges < 50) m_edges++;
        end
    end

    // ---------------- per-cycle comparison ----------------
    int          seen_vld, seen_err;
    logic [31:0] last_word;

    always @(negedge clk) begin
        #1;
        chk(word_vld === e_vld, "R7 word_vld", {31'd0, word_vld}, {31'd0, e_vld});
        if (e_vld) chk(word_dat === e_dat, "R5/R6 word_dat", word_dat, e_dat);
        chk(err === e_err, "R8 err", {31'd0, err}, {31'd0, e_err});
        chk(ready === (m_ph == 3), "R9 ready", {31'd0, ready}, {31'd0, m_ph == 3});
        if (word_vld === 1'b1) begin seen_vld++; last_word = word_dat; end
        if (err === 1'b1) seen_err++;
    end

    // ---------------- stimulus helpers ----------------
    task automatic do_reset(input logic wide);
        @(negedge clk);
        rst_n = 1'b0; sel_n = 1'b1; wr_n = 1'b1; done_i = 1'b0; wide_i = wide;
        repeat (55) @(negedge clk);
        // R1: outputs quiet during reset
        chk(word_vld === 1'b0 && err === 1'b0 && ready === 1'b0, "R1 reset outputs",
            {29'd0, word_vld, err, ready}, 32'd0);
        seen_vld = 0; seen_err = 0; last_word = '0;
        rst_n = 1'b1;
    endtask

    task automatic beat(input logic [15:0] d);
        sel_n = 1'b0; wr_n = 1'b0; bus_d = d;
        @(negedge clk);
        sel_n = 1'b1; wr_n = 1'b1; bus_d = 16'hFFFF;
    endtask

    // R2: select low with write high must not count as a beat
    task automatic ghost(input logic [15:0] d);
        sel_n = 1'b0; wr_n = 1'b1; bus_d = d;
        @(negedge clk);
        sel_n = 1'b1; bus_d = 16'hFFFF;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic word8(input logic [31:0] w, input int gap);
        for (int i = 0; i < 4; i++) begin
            beat({8'h00, w[8*i +: 8]});
            if (gap > 0) begin ghost(16'h5A5A); idle(gap - 1); end
        end
    endtask

    task automatic word16(input logic [31:0] w, input int gap);
        for (int i = 0; i < 2; i++) begin
            beat(w[16*i +: 16]);
            if (gap > 0) begin ghost(16'hA5A5); idle(gap - 1); end
        end
    endtask

    task automatic pulse_done(input int n);
        done_i = 1'b1; idle(n); done_i = 1'b0;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        // ---- 8-bit mode, gaps and ghost beats ----
        do_reset(1'b0);
        @(negedge clk); #1;
        chk(word_vld === 1'b0 && err === 1'b0 && ready === 1'b0, "R1 after release",
            {29'd0, word_vld, err, ready}, 32'd0);
        idle(52);
        word8(SYNC, 0);
        word8(32'hA1B2_C3D4, 3);   // R3 idle gaps plus R2 ghost beats
        word8(32'h0F1E_2D3C, 0);
        idle(4);
        chk(seen_vld == 2, "R7 sync consumed, two words forwarded", seen_vld, 2);
        chk(last_word == 32'h0F1E_2D3C, "R5 byte order", last_word, 32'h0F1E_2D3C);
        chk(seen_err == 0, "R3 gaps keep alignment", seen_err, 0);
        pulse_done(1);
        idle(2);
        chk(ready === 1'b1, "R9 ready after done", {31'd0, ready}, 32'd1);
        word8(32'hDEAD_BEEF, 0);
        idle(4);
        chk(seen_vld == 2, "R10 beats after ready discarded", seen_vld, 2);
        chk(ready === 1'b1, "R9 ready sticky", {31'd0, ready}, 32'd1);

        // ---- 16-bit mode, early done ----
        do_reset(1'b1);
        @(negedge clk); #1;
        chk(ready === 1'b0, "R1 ready cleared by reset", {31'd0, ready}, 32'd0);
        idle(52);
        pulse_done(3);
        idle(1);
        chk(ready === 1'b0, "R9 done before any word ignored", {31'd0, ready}, 32'd0);
        word16(SYNC, 1);
        word16(32'h89AB_CDEF, 3);
        word16(32'h00FF_5AA5, 0);
        idle(4);
        chk(seen_vld == 2, "R6 two words in 16-bit mode", seen_vld, 2);
        chk(last_word == 32'h00FF_5AA5, "R6 halfword order", last_word, 32'h00FF_5AA5);
        pulse_done(1);
        idle(2);
        chk(ready === 1'b1, "R9 ready in 16-bit mode", {31'd0, ready}, 32'd1);

        // ---- bad sync word ----
        do_reset(1'b0);
        idle(52);
        word8(32'h1234_5679, 0);
        word8(32'h1111_1111, 1);
        word8(SYNC, 0);
        idle(4);
        chk(seen_err == 1, "R8 single error pulse", seen_err, 1);
        chk(seen_vld == 0, "R8 nothing forwarded after bad sync", seen_vld, 0);
        pulse_done(1);
        idle(2);
        chk(ready === 1'b0, "R8 locked port ignores done", {31'd0, ready}, 32'd0);

        // ---- blackout boundary: beats from edge 1 onward ----
        do_reset(1'b0);
        for (int i = 0; i < 50; i++) beat(16'h00AA);
        word8(SYNC, 0);
        word8(32'hCAFE_F00D, 0);
        idle(4);
        chk(seen_err == 0, "R4 edges 1..50 rejected, edge 51 accepted", seen_err, 0);
        chk(seen_vld == 1, "R4 word after blackout forwarded", seen_vld, 1);
        chk(last_word == 32'hCAFE_F00D, "R4 word value after blackout", last_word, 32'hCAFE_F00D);

        idle(3);
        finish_run();
    end

endmodule